// File: doc/BRIEF.md
# TDM Output Stream Alignment Shifter

This block turns byte-wide channel data into one serial TDM output line. It places every bit on the line relative to an output frame pulse. Each stream instance has a 5-bit offset setting. The upper three bits push the whole frame later by 0 to 7 bit periods. The lower two bits pull every bit transition earlier by 0 to 3 quarter-bit periods. These two adjustments let a board compensate for skew and for loading on each serial output separately.

The block runs on a clock at four times the selected bit rate, so one bit period is four clock ticks. A rate-mode input selects a frame of 32, 64 or 128 channels. The block fetches each channel byte through a simple request and return interface, one bit period before the byte's first bit is due. One instance drives one stream; a chip with many streams places one instance per stream, each with its own offset.

Top module: `tdm_align_shifter`

## Requirements
- R1: After reset, and until the first frame pulse is sampled, `sdo_o` is 1 and `req_o` is 0.
- R2: With offset 0, the clock tick right after the edge that samples `fp_i` high carries bit 7 of channel 0. Each bit is held for 4 ticks, and bits follow MSB first down to bit 0, channel after channel.
- R3: Offset bits [4:2] give a delay D in bit periods. Every bit appears 4·D ticks later than with D = 0. The last 4·D ticks of the previous frame's final channel are wrapped to the start of the frame, ahead of bit 7 of channel 0.
- R4: Offset bits [1:0] give an advance A. Every bit transition occurs A ticks earlier than its nominal position.
- R5: Delay and advance combine: the first tick after the frame pulse shows frame position (A − 4·D) mod L, where L is the frame length in ticks.
- R6: Rate mode 0 gives 32 channels, mode 1 gives 64, and modes 2 and 3 give 128. The frame length L is the channel count × 32 ticks. The position wraps at L even if no further pulse arrives.
- R7: `req_o` is a one-tick pulse in the tick where the frame position is 28 modulo 32. `chan_o` holds the index of the following channel, wrapping from the last channel to 0. `byte_i` is sampled on the second rising edge after the edge that raised `req_o`. There is exactly one request per channel in each frame.
- R8: `rate_i` and `offset_i` are sampled only on the edge that samples `fp_i` high. A change between pulses has no effect on the current frame. After a pulse that changes the alignment, the byte in progress at that pulse is transitional; all later bits follow the new setting.
- R9: Away from a frame pulse, `sdo_o` changes only at bit-period boundaries of the current alignment, so each level is held for at least 4 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at four times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fp_i | input | 1 | Output frame pulse, one clock tick high |
| rate_i | input | 2 | Rate mode: 0 = 32, 1 = 64, 2 or 3 = 128 channels |
| offset_i | input | 5 | [4:2] whole-bit delay, [1:0] quarter-bit advance |
| req_o | output | 1 | Channel byte request pulse |
| chan_o | output | 7 | Channel index for the request |
| byte_i | input | 8 | Returned channel byte |
| sdo_o | output | 1 | Serial data output |

## Verification
The serializer is driven with zero offset, with a delay alone (including the maximum of 7), with an advance alone, and with both together. Comparing these runs separates a wrong shift direction, a wrong bit/tick scale and a missing wrap of the last channel. Runs in each rate mode show whether the frame length and the wrap of the channel index follow the mode. A run that changes rate and offset in the middle of a frame shows whether they are sampled only at the pulse. Every run also checks the request timing and channel order against the data that comes back, so a prefetch that comes too late, or fetches the wrong channel, shows up as wrong bits.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SUB_LOG2 = 2;                     // ticks per bit = 4
  localparam int unsigned BIT_LOG2 = $clog2(BYTE_W);
  localparam int unsigned CH_W     = 7;                     // up to 128 channels
  localparam int unsigned SLOT_W   = SUB_LOG2 + BIT_LOG2;   // ticks per channel
  localparam int unsigned POS_W    = CH_W + SLOT_W;
  localparam int unsigned OFF_W    = BIT_LOG2 + SUB_LOG2;

  // slot where the next byte is requested: one bit period before slot 0
  localparam logic [SLOT_W-1:0] FETCH_SLOT =
    SLOT_W'((1 << SLOT_W) - (1 << SUB_LOG2));

  typedef enum logic [1:0] {
    RATE_LOW      = 2'd0,
    RATE_MID      = 2'd1,
    RATE_HIGH     = 2'd2,
    RATE_HIGH_ALT = 2'd3
  } rate_t;

  function automatic logic [CH_W-1:0] last_chan(input rate_t r);
    case (r)
      RATE_LOW: last_chan = CH_W'(31);
      RATE_MID: last_chan = CH_W'(63);
      default:  last_chan = CH_W'(127);
    endcase
  endfunction

  function automatic logic [POS_W-1:0] last_pos(input rate_t r);
    last_pos = {last_chan(r), {SLOT_W{1'b1}}};
  endfunction

  // frame position shown in the first tick after the pulse: (A - 4D) mod L
  function automatic logic [POS_W-1:0] start_pos(input rate_t r,
                                                 input logic [OFF_W-1:0] off);
    logic [BIT_LOG2-1:0] dly;
    logic [SUB_LOG2-1:0] adv;
    dly = off[OFF_W-1:SUB_LOG2];
    adv = off[SUB_LOG2-1:0];
    if (dly == '0)
      start_pos = POS_W'(adv);
    else
      start_pos = last_pos(r) + POS_W'(1) - (POS_W'(dly) << SUB_LOG2)
                  + POS_W'(adv);
  endfunction

endpackage

// File: rtl/tdm_phase_ctr.sv
module tdm_phase_ctr
  import tdm_align_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_i,
  input  logic [1:0]       rate_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_nx,
  output logic             run_q,
  output logic             run_nx,
  output rate_t            rate_nx
);

  rate_t rate_q;
  logic  pos_en;

  always_comb begin
    pos_en  = fp_i | run_q;
    pos_nx  = pos_q;
    run_nx  = run_q;
    rate_nx = rate_q;
    if (fp_i) begin
      rate_nx = rate_t'(rate_i);
      run_nx  = 1'b1;
      pos_nx  = start_pos(rate_t'(rate_i), offset_i);
    end else if (run_q) begin
      pos_nx = (pos_q == last_pos(rate_q)) ? '0 : pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      run_q  <= 1'b0;
      rate_q <= RATE_LOW;
    end else if (pos_en) begin
      pos_q  <= pos_nx;
      run_q  <= run_nx;
      rate_q <= rate_nx;
    end
  end

endmodule

// File: rtl/tdm_byte_fetch.sv
module tdm_byte_fetch
  import tdm_align_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  pos_nx,
  input  logic              run_nx,
  input  rate_t             rate_nx,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              req_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [BYTE_W-1:0] nxt_byte
);

  logic              req_d, pend_q;
  logic [CH_W-1:0]   cur_ch, chan_d;

  always_comb begin
    req_d  = run_nx && (pos_nx[SLOT_W-1:0] == FETCH_SLOT);
    cur_ch = pos_nx[POS_W-1:SLOT_W];
    chan_d = (cur_ch == last_chan(rate_nx)) ? '0 : cur_ch + CH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_o  <= req_d;
      pend_q <= req_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chan_o <= '0;
    else if (req_d) chan_o <= chan_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nxt_byte <= '0;
    else if (pend_q) nxt_byte <= byte_i;
  end

endmodule

// File: rtl/tdm_bit_out.sv
module tdm_bit_out
  import tdm_align_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  pos_q,
  input  logic [POS_W-1:0]  pos_nx,
  input  logic              run_q,
  input  logic              run_nx,
  input  logic [BYTE_W-1:0] nxt_byte,
  output logic              sdo_o
);

  logic [BYTE_W-1:0]   cur_q;
  logic                load_en;
  logic [BIT_LOG2-1:0] bit_sel;

  always_comb begin
    load_en = run_nx && (pos_nx[SLOT_W-1:0] == '0);
    bit_sel = ~pos_q[SLOT_W-1:SUB_LOG2];   // slot bit 0 -> data bit 7
    sdo_o   = run_q ? cur_q[bit_sel] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= '0;
    else if (load_en) cur_q <= nxt_byte;
  end

endmodule

// File: rtl/tdm_align_shifter.sv
module tdm_align_shifter
  import tdm_align_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_i,
  input  logic [1:0]        rate_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic              req_o,
  output logic [CH_W-1:0]   chan_o,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              sdo_o
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [POS_W-1:0]  pos_q, pos_nx;
  logic              run_q, run_nx;
  rate_t             rate_nx;
  logic [BYTE_W-1:0] nxt_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  tdm_phase_ctr u_phase (
    .clk(clk), .rst_n(rst_core_n), .fp_i(fp_i), .rate_i(rate_i),
    .offset_i(offset_i), .pos_q(pos_q), .pos_nx(pos_nx),
    .run_q(run_q), .run_nx(run_nx), .rate_nx(rate_nx)
  );

  tdm_byte_fetch u_fetch (
    .clk(clk), .rst_n(rst_core_n), .pos_nx(pos_nx), .run_nx(run_nx),
    .rate_nx(rate_nx), .byte_i(byte_i), .req_o(req_o), .chan_o(chan_o),
    .nxt_byte(nxt_byte)
  );

  tdm_bit_out u_out (
    .clk(clk), .rst_n(rst_core_n), .pos_q(pos_q), .pos_nx(pos_nx),
    .run_q(run_q), .run_nx(run_nx), .nxt_byte(nxt_byte), .sdo_o(sdo_o)
  );

endmodule

// File: rtl/tdm_align_checker.sv
module tdm_align_checker
  import tdm_align_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            fp_i,
  input logic [1:0]      rate_i,
  input logic            req_o,
  input logic [CH_W-1:0] chan_o,
  input logic            sdo_o
);

  logic       seen_q;
  rate_t      rate_lat;
  logic       prev_sdo;
  logic [1:0] hold_cnt;
  logic [3:0] quiet_cnt;
  logic       quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      rate_lat  <= RATE_LOW;
      prev_sdo  <= 1'b1;
      hold_cnt  <= '0;
      quiet_cnt <= '0;
    end else begin
      prev_sdo <= sdo_o;
      if (sdo_o != prev_sdo)   hold_cnt <= '0;
      else if (hold_cnt != 2'd3) hold_cnt <= hold_cnt + 2'd1;
      if (fp_i) begin
        seen_q    <= 1'b1;
        rate_lat  <= rate_t'(rate_i);
        quiet_cnt <= '0;
      end else if (quiet_cnt != 4'd12) begin
        quiet_cnt <= quiet_cnt + 4'd1;
      end
    end
  end

  assign quiet = seen_q && (quiet_cnt == 4'd12);

  // R1: idle line before the first frame pulse
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (sdo_o && !req_o));

  // R7: requests are single-tick pulses
  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !fp_i) |=> !req_o);

  // R6: requested channel lies inside the frame of the latched mode
  a_r6_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (chan_o <= last_chan(rate_lat)));

  // R9: away from a pulse, every level lasts a full bit period
  a_r9_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && (sdo_o != prev_sdo)) |-> (hold_cnt == 2'd3));

endmodule

bind tdm_align_shifter tdm_align_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rate_i(rate_i),
  .req_o(req_o), .chan_o(chan_o), .sdo_o(sdo_o)
);

// File: tb/tdm_align_shifter_test.sv
module tdm_align_shifter_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk;
  logic       rst_n;
  logic       fp_i;
  logic [1:0] rate_i;
  logic [4:0] offset_i;
  logic       req_o;
  logic [6:0] chan_o;
  logic [7:0] byte_i;
  logic       sdo_o;

  int  vectors;
  int  miscompares;
  bit  done;

  tdm_align_shifter uut (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rate_i(rate_i),
    .offset_i(offset_i), .req_o(req_o), .chan_o(chan_o),
    .byte_i(byte_i), .sdo_o(sdo_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int nch_of(input logic [1:0] r);
    return (r == 2'd0) ? 32 : (r == 2'd1) ? 64 : 128;
  endfunction

  function automatic logic [7:0] pat(input int c);
    return 8'((c * 37) % 256) ^ 8'hA5;
  endfunction

  function automatic int pos_of(input logic [1:0] r, input logic [4:0] o,
                                input int k);
    int len, d, a, st;
    len = nch_of(r) * 32;
    d   = int'(o[4:2]);
    a   = int'(o[1:0]);
    st  = (d == 0) ? a : len - 4 * d + a;
    return (st + k) % len;
  endfunction

  function automatic logic exp_bit(input logic [1:0] r, input int s);
    logic [7:0] b;
    b = pat(s / 32);
    return b[7 - ((s / 4) % 8)];
  endfunction

  task automatic check(input bit ok, input string tag, input int act,
                       input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // channel byte source: answers a request before the sampling edge (R7)
  initial begin
    forever begin
      @(negedge clk);
      if (req_o) byte_i = pat(int'(chan_o));
    end
  end

  task automatic do_reset();
    int bad;
    bad      = 0;
    rst_n    = 1'b0;
    fp_i     = 1'b0;
    rate_i   = 2'd0;
    offset_i = 5'd0;
    byte_i   = 8'd0;
    repeat (4) @(negedge clk);
    if (sdo_o !== 1'b1 || req_o !== 1'b0) bad++;
    rst_n = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (sdo_o !== 1'b1 || req_o !== 1'b0) bad++;
    end
    check(bad == 0, "R1 idle line before first pulse", bad, 0);
  endtask

  // Runs nfr back-to-back frames. Settings (r1,o1) are applied at tick
  // chg_k of frame chg_f; frames after chg_f use them. Frames from chk_from
  // on are checked; frame chg_f+1 skips its first skip_n ticks.
  task automatic run_frames(input logic [1:0] r0, input logic [4:0] o0,
                            input logic [1:0] r1, input logic [4:0] o1,
                            input int nfr, input int chg_f, input int chg_k,
                            input int chk_from, input int skip_n,
                            input string tag);
    rate_i   = r0;
    offset_i = o0;
    @(negedge clk);
    fp_i = 1'b1;
    for (int f = 0; f < nfr; f++) begin
      logic [1:0] fr;
      logic [4:0] fo;
      int len, bit_err, req_err, edge_err, nreq, ereq, s, es, ech;
      int first_act, first_exp;
      logic prev;
      fr = (f > chg_f) ? r1 : r0;
      fo = (f > chg_f) ? o1 : o0;
      len = nch_of(fr) * 32;
      bit_err = 0; req_err = 0; edge_err = 0; nreq = 0; ereq = 0;
      first_act = 0; first_exp = 0; prev = 1'b0;
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        fp_i = 1'b0;
        if (f == chg_f && k == chg_k) begin
          rate_i   = r1;
          offset_i = o1;
        end
        s = pos_of(fr, fo, k);
        if (!(f == chg_f + 1 && k < skip_n)) begin
          es = int'(exp_bit(fr, s));
          if (sdo_o !== es[0]) begin
            if (bit_err == 0) begin
              first_act = int'(sdo_o);
              first_exp = es;
            end
            bit_err++;
          end
          if (k > 0 && !(f == chg_f + 1 && k <= skip_n) &&
              sdo_o !== prev && (s % 4) != 0)
            edge_err++;
          ech = (s / 32 + 1) % nch_of(fr);
          if ((s % 32) == 28) begin
            ereq++;
            if (req_o !== 1'b1 || int'(chan_o) != ech) req_err++;
          end else if (req_o !== 1'b0) begin
            req_err++;
          end
          if (req_o === 1'b1) nreq++;
        end
        prev = sdo_o;
        if (k == len - 1 && f < nfr - 1) fp_i = 1'b1;
      end
      if (f >= chk_from) begin
        check(bit_err == 0, {tag, " serial bits"}, first_act, first_exp);
        check(req_err == 0 && nreq == ereq,
              {tag, " R7 request timing/channel"}, nreq, ereq);
        check(edge_err == 0, {tag, " R9 bit-period edges"}, edge_err, 0);
      end
    end
  endtask

  task automatic test_default();
    run_frames(2'd0, 5'd0, 2'd0, 5'd0, 2, -1, 0, 1, 0, "R2 zero offset");
  endtask

  task automatic test_delay();
    run_frames(2'd0, 5'b011_00, 2'd0, 5'b011_00, 2, -1, 0, 1, 0,
               "R3 delay 3");
    run_frames(2'd0, 5'b111_00, 2'd0, 5'b111_00, 2, -1, 0, 1, 0,
               "R3 delay 7 wrap");
  endtask

  task automatic test_advance();
    run_frames(2'd0, 5'b000_10, 2'd0, 5'b000_10, 2, -1, 0, 1, 0,
               "R4 advance 2");
    run_frames(2'd0, 5'b000_11, 2'd0, 5'b000_11, 2, -1, 0, 1, 0,
               "R4 advance 3");
  endtask

  task automatic test_combined();
    run_frames(2'd0, 5'b101_01, 2'd0, 5'b101_01, 2, -1, 0, 1, 0,
               "R5 delay 5 advance 1");
  endtask

  task automatic test_rates();
    run_frames(2'd1, 5'b001_10, 2'd1, 5'b001_10, 2, -1, 0, 1, 0,
               "R6 mode 1");
    run_frames(2'd2, 5'd0, 2'd2, 5'd0, 2, -1, 0, 1, 0, "R6 mode 2");
    run_frames(2'd3, 5'b010_11, 2'd3, 5'b010_11, 2, -1, 0, 1, 0,
               "R6 mode 3");
  endtask

  task automatic test_midframe_change();
    // frame 1 must keep mode 0 / offset 0 throughout; frame 2 follows
    // mode 1 with delay 2 advance 1 after the transitional byte
    run_frames(2'd0, 5'd0, 2'd1, 5'b010_01, 3, 1, 500, 1, 40,
               "R8 mid-frame change");
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    done        = 1'b0;
    do_reset();
    test_default();
    test_delay();
    test_advance();
    test_combined();
    test_rates();
    test_midframe_change();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors,
             miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors,
               miscompares);
      $finish;
    end
  end

endmodule